// File: doc/BRIEF.md
# Type 0 Configuration Cycle Generator

This block sits between a host CPU and a simplified PCI target handshake. Software first loads a 32-bit configuration address word through a register-write port. A configuration read or write request then becomes either a Type 0 address phase on the bus side, or an immediate local completion. In the address phase the device number is decoded into a single select bit in the upper address lines, and the function and register numbers are passed through below it.

After the address phase the block waits a fixed number of cycles for a target acknowledge. If an acknowledge arrives, the block returns the target's read data. If none arrives, the transaction ends as a master abort. The requester sees an ordinary completion: a write simply finishes, and a read returns zero. The block has no interrupt output, so an abort is never signalled. Only one transaction is in flight at a time.

Top module: `cfg0_access_gen`

## Requirements
- R1: After reset the block is idle, with `reqReady`=1, `busValid`=0 and `rspValid`=0. The stored configuration word is all zero, so access is disabled.
- R2: The configuration word has its enable flag at bit 31. When that flag is 0, an accepted request produces no address phase. `rspValid` is high in the cycle after acceptance, with `rspRdData`=0.
- R3: The configuration word holds the register number at bits 7:2, the function number at 10:8 and the device number N at 15:11. The address phase drives `busAddr` with bit 11+N as the only set bit among bits 31:11, the function number at 10:8, the register number at 7:2 and zeros at 1:0. Bits 30:16 of the word have no effect on the address.
- R4: A device number above 20 gives no select bit. The request then completes locally, exactly as in R2.
- R5: An enabled request with a valid device number raises `busValid` for exactly one cycle: the cycle after acceptance. During that cycle `busWrite` and `busWrData` carry the request's direction and write data.
- R6: If `tgtAck` is sampled high in wait cycle k (k = 1..TIMEOUT, where wait cycle 1 follows the address phase), `rspValid` rises in the next cycle. A read returns the `tgtRdData` captured with the acknowledge. A write returns 0.
- R7: If no acknowledge arrives in the TIMEOUT wait cycles, the transaction ends as a master abort. `rspValid` is high TIMEOUT+1 cycles after the address-phase cycle, and `rspRdData`=0 whatever the target data lines carry.
- R8: `reqReady` is low from acceptance until after the `rspValid` cycle. Requests raised in that window start no address phase and produce no response.
- R9: A register write made while a transaction is in flight leaves that transaction's `busAddr` unchanged. It applies to the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Load strobe for the configuration word |
| regWrData | input | 32 | New configuration word |
| reqValid | input | 1 | Configuration request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWrData | input | 32 | Write data of the request |
| reqReady | output | 1 | Block idle, request will be taken |
| busValid | output | 1 | Address-phase strobe |
| busAddr | output | 32 | Type 0 address of the current transaction |
| busWrite | output | 1 | Direction of the current transaction |
| busWrData | output | 32 | Write data of the current transaction |
| tgtAck | input | 1 | Target acknowledge during the wait window |
| tgtRdData | input | 32 | Target read data, valid with `tgtAck` |
| rspValid | output | 1 | One-cycle completion strobe |
| rspRdData | output | 32 | Completion read data |

## Verification
The hardest case to reach from the ports is a register write and a second request that both land while a master abort is still counting down. The stimulus drives both one cycle into the wait window of an unacknowledged read. It then checks that the address stays put, that the stray request draws neither an address phase nor a response, and that a follow-up request uses the new word. The acknowledge is placed in the first and in the last wait cycle to pin down both edges of the timeout window.

// File: rtl/cfg0_pkg.sv
package cfg0_pkg;
  localparam int ADDR_W  = 32;
  localparam int SEL_LSB = 11;
  localparam int SEL_W   = ADDR_W - SEL_LSB;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_RESP
  } cfgState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // capture request and decoded address
    logic loadRsp;   // capture target data (zero for writes)
    logic zeroRsp;   // completion without target data
  } cfgStrobes_t;
endpackage

// File: rtl/cfg0_datapath.sv
module cfg0_datapath
  import cfg0_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [AW-1:0] regWrData,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqWrData,
  input  logic [AW-1:0] tgtRdData,
  input  cfgStrobes_t   strobes,
  output logic          cfgEnable,
  output logic          devOk,
  output logic [AW-1:0] busAddr,
  output logic          busWrite,
  output logic [AW-1:0] busWrData,
  output logic [AW-1:0] rspRdData
);
  localparam int SW = AW - SEL_LSB;

  logic [AW-1:0] cfgReg;
  logic [4:0]    devNum;
  logic [SW-1:0] selVec;
  logic [AW-1:0] addrNext;
  logic          unusedCfg;

  always_ff @(posedge clk) begin
    if (!rstN)        cfgReg <= '0;
    else if (regWrEn) cfgReg <= regWrData;
  end

  assign devNum    = cfgReg[15:11];
  assign cfgEnable = cfgReg[AW-1];
  assign unusedCfg = ^cfgReg[AW-2:16];

  // one select line per reachable device slot
  for (genvar i = 0; i < SW; i++) begin : g_sel
    assign selVec[i] = (int'(devNum) == i);
  end

  assign devOk    = |selVec;
  assign addrNext = {selVec, cfgReg[10:8], cfgReg[7:2], 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddr   <= '0;
      busWrite  <= 1'b0;
      busWrData <= '0;
    end else if (strobes.latchReq) begin
      busAddr   <= addrNext;
      busWrite  <= reqWrite;
      busWrData <= reqWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rspRdData <= '0;
    else if (strobes.loadRsp)  rspRdData <= busWrite ? '0 : tgtRdData;
    else if (strobes.zeroRsp)  rspRdData <= '0;
  end
endmodule

// File: rtl/cfg0_control.sv
module cfg0_control
  import cfg0_pkg::*;
#(
  parameter int TIMEOUT = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        tgtAck,
  input  logic        cfgEnable,
  input  logic        devOk,
  output cfgStrobes_t strobes,
  output logic        busValid,
  output logic        rspValid,
  output logic        busy
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  cfgState_t  state, stateNext;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobes.latchReq = 1'b1;
        if (cfgEnable && devOk) stateNext = ST_ADDR;
        else begin
          strobes.zeroRsp = 1'b1;
          stateNext       = ST_RESP;
        end
      end
      ST_ADDR: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (tgtAck) begin
          strobes.loadRsp = 1'b1;
          stateNext       = ST_RESP;
        end else if (waitCnt == CNT_W'(TIMEOUT - 1)) begin
          strobes.zeroRsp = 1'b1;
          stateNext       = ST_RESP;
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_WAIT) waitCnt <= waitCnt + 1'b1;
      else                  waitCnt <= '0;
    end
  end

  assign busValid = (state == ST_ADDR);
  assign rspValid = (state == ST_RESP);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/cfg0_access_gen.sv
module cfg0_access_gen
  import cfg0_pkg::*;
#(
  parameter int TIMEOUT = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqWrData,
  output logic        reqReady,
  output logic        busValid,
  output logic [31:0] busAddr,
  output logic        busWrite,
  output logic [31:0] busWrData,
  input  logic        tgtAck,
  input  logic [31:0] tgtRdData,
  output logic        rspValid,
  output logic [31:0] rspRdData
);
  cfgStrobes_t strobes;
  logic cfgEnable, devOk, busy;

  cfg0_control #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .tgtAck(tgtAck),
    .cfgEnable(cfgEnable), .devOk(devOk), .strobes(strobes),
    .busValid(busValid), .rspValid(rspValid), .busy(busy)
  );

  cfg0_datapath #(.AW(32)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .reqWrite(reqWrite), .reqWrData(reqWrData), .tgtRdData(tgtRdData),
    .strobes(strobes), .cfgEnable(cfgEnable), .devOk(devOk),
    .busAddr(busAddr), .busWrite(busWrite), .busWrData(busWrData),
    .rspRdData(rspRdData)
  );

  assign reqReady = !busy;
endmodule

// File: rtl/cfg0_checker.sv
module cfg0_checker #(
  parameter int TIMEOUT = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        busValid,
  input logic [31:0] busAddr,
  input logic        rspValid,
  input logic [31:0] rspRdData
);
  logic        inFlight;
  int unsigned sinceAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight  <= 1'b0;
      sinceAddr <= 0;
    end else if (busValid) begin
      inFlight  <= 1'b1;
      sinceAddr <= 0;
    end else if (rspValid) begin
      inFlight  <= 1'b0;
    end else if (inFlight) begin
      sinceAddr <= sinceAddr + 1;
    end
  end

  assert_addr_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> !busValid);

  assert_addr_after_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> $past(reqValid && reqReady));

  assert_addr_format_R3: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busAddr[1:0] == 2'b00 && $onehot(busAddr[31:11])));

  assert_no_accept_in_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_timeout_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> (sinceAddr <= TIMEOUT));

  assert_local_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !inFlight) |-> (rspRdData == 32'h0));
endmodule

bind cfg0_access_gen cfg0_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .busValid(busValid), .busAddr(busAddr), .rspValid(rspValid),
  .rspRdData(rspRdData)
);

// File: tb/test_cfg0_access_gen.sv
`timescale 1ns/1ps
module test_cfg0_access_gen;
  localparam int TIMEOUT = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0, reqValid = 1'b0, reqWrite = 1'b0, tgtAck = 1'b0;
  logic [31:0] regWrData = '0, reqWrData = '0, tgtRdData = '0;
  logic reqReady, busValid, busWrite, rspValid;
  logic [31:0] busAddr, busWrData, rspRdData;

  int checks = 0, fails = 0;
  logic [31:0] expQ[$];

  always #10 clk = ~clk;

  cfg0_access_gen #(.TIMEOUT(TIMEOUT)) i_cfg0_access_gen (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqWrData(reqWrData),
    .reqReady(reqReady), .busValid(busValid), .busAddr(busAddr),
    .busWrite(busWrite), .busWrData(busWrData), .tgtAck(tgtAck),
    .tgtRdData(tgtRdData), .rspValid(rspValid), .rspRdData(rspRdData)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgWord(input bit en, input int bus, input int dev, input int fn, input int rg);
    return (32'(en) << 31) | (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | (32'(rg) << 2);
  endfunction

  function automatic logic [31:0] t0Addr(input int dev, input int fn, input int rg);
    return (32'h1 << (11 + dev)) | (32'(fn) << 8) | (32'(rg) << 2);
  endfunction

  // monitor: pops expected completion data
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) check(1'b0, "R8 unexpected response", rspRdData, 32'h0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(rspRdData == e, "R6/R7 response data", rspRdData, e);
      end
    end
  end

  task automatic writeReg(input logic [31:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic doReq(input bit wr, input logic [31:0] wd, input bit expBus,
                       input logic [31:0] expAddr, input int ackAt,
                       input logic [31:0] ackData, input bit disturb,
                       input logic [31:0] disturbWord, input logic [31:0] expRd,
                       input int expLat, input string tag);
    int n;
    bit done;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWrData = wd;
    expQ.push_back(expRd);
    @(negedge clk);
    reqValid = 1'b0;
    n = 1; done = 1'b0;
    while (!done) begin
      if (n == 1) begin
        check(busValid == expBus, {tag, " R5 address phase strobe"}, 32'(busValid), 32'(expBus));
        if (expBus) begin
          check(busAddr == expAddr, {tag, " R3 address"}, busAddr, expAddr);
          check(busWrite == wr, {tag, " R5 direction"}, 32'(busWrite), 32'(wr));
          check(busWrData == wd, {tag, " R5 write data"}, busWrData, wd);
        end
      end else begin
        check(busValid == 1'b0, {tag, " R5/R8 no extra address phase"}, 32'(busValid), 32'h0);
      end
      if (disturb && n == 2) begin
        check(reqReady == 1'b0, {tag, " R8 busy"}, 32'(reqReady), 32'h0);
        reqValid = 1'b1; reqWrite = 1'b0;
        regWrEn = 1'b1; regWrData = disturbWord;
      end
      if (disturb && n == 3) begin
        regWrEn = 1'b0;
        check(busAddr == expAddr, {tag, " R9 address held"}, busAddr, expAddr);
      end
      tgtRdData = ackData;
      tgtAck = (ackAt != 0 && n == 1 + ackAt);
      if (rspValid) begin
        check(n == expLat, {tag, " R2/R6/R7 latency"}, 32'(n), 32'(expLat));
        reqValid = 1'b0;
        done = 1'b1;
      end else if (n > 30) begin
        check(1'b0, {tag, " R8 no completion"}, 32'(n), 32'(expLat));
        done = 1'b1;
      end
      if (!done) begin
        @(negedge clk);
        n++;
      end
    end
    tgtAck = 1'b0;
    @(negedge clk);
    check(reqReady == 1'b1 && rspValid == 1'b0, {tag, " R8 idle after response"}, 32'(reqReady), 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady", 32'(reqReady), 32'h1);
    check(busValid == 1'b0, "R1 busValid", 32'(busValid), 32'h0);
    check(rspValid == 1'b0, "R1 rspValid", 32'(rspValid), 32'h0);

    // R1/R2: reset word is disabled, completes locally
    doReq(1'b0, 32'h0, 1'b0, 32'h0, 0, 32'h5555_AAAA, 1'b0, 32'h0, 32'h0, 1, "R1/R2 disabled read");

    // R3/R6: device 0, ack in first wait cycle
    writeReg(cfgWord(1, 8'h5A, 0, 3, 5));
    doReq(1'b0, 32'h0, 1'b1, t0Addr(0, 3, 5), 1, 32'hA5A5_1234, 1'b0, 32'h0, 32'hA5A5_1234, 3, "R6 read ack1");

    // R3 reserved bits ignored, device 20, R6 write ack in last wait cycle
    writeReg(cfgWord(1, 8'hFF, 20, 7, 63) | 32'h7F00_0000);
    doReq(1'b1, 32'hDEAD_BEEF, 1'b1, t0Addr(20, 7, 63), TIMEOUT, 32'hFFFF_FFFF, 1'b0, 32'h0, 32'h0, 2 + TIMEOUT, "R6 write ack last");

    // R7 read master abort
    writeReg(cfgWord(1, 1, 7, 2, 9));
    doReq(1'b0, 32'h0, 1'b1, t0Addr(7, 2, 9), 0, 32'hCAFE_F00D, 1'b0, 32'h0, 32'h0, TIMEOUT + 2, "R7 read abort");

    // R7 write master abort
    writeReg(cfgWord(1, 0, 9, 0, 1));
    doReq(1'b1, 32'h1234_5678, 1'b1, t0Addr(9, 0, 1), 0, 32'h0BAD_0BAD, 1'b0, 32'h0, 32'h0, TIMEOUT + 2, "R7 write abort");

    // R4 device out of range
    writeReg(cfgWord(1, 0, 21, 1, 1));
    doReq(1'b0, 32'h0, 1'b0, 32'h0, 0, 32'h7777_7777, 1'b0, 32'h0, 32'h0, 1, "R4 dev21 read");
    writeReg(cfgWord(1, 0, 31, 1, 1));
    doReq(1'b1, 32'h9999_0000, 1'b0, 32'h0, 0, 32'h7777_7777, 1'b0, 32'h0, 32'h0, 1, "R4 dev31 write");

    // R8/R9: stray request and register write during an abort wait
    writeReg(cfgWord(1, 0, 2, 4, 10));
    doReq(1'b0, 32'h0, 1'b1, t0Addr(2, 4, 10), 0, 32'h4444_4444, 1'b1, cfgWord(1, 0, 3, 5, 11), 32'h0, TIMEOUT + 2, "R8/R9 disturbed abort");
    doReq(1'b0, 32'h0, 1'b1, t0Addr(3, 5, 11), 2, 32'h0102_0304, 1'b0, 32'h0, 32'h0102_0304, 4, "R9 new word used");

    // R2 disabled with a valid device field
    writeReg(cfgWord(0, 0, 4, 0, 0));
    doReq(1'b1, 32'hFEED_FACE, 1'b0, 32'h0, 0, 32'h3333_3333, 1'b0, 32'h0, 32'h0, 1, "R2 disabled write");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8 all responses seen", 32'(expQ.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule